// File: doc/BRIEF.md
# Moore-Type Bit-Serial Adder

This block adds two unsigned N-bit operands one bit position per clock. While reset is held, both operands are captured in parallel into right-shifting registers. Once reset is released, the lowest bit of each operand is fed to a four-state Moore machine each clock. That machine keeps the running carry and the sum bit of the previous position in its two state bits.

Because the sum bit is a state bit, the sum bit for operand position k is ready one clock after positions k of the operands are presented. For this reason the result register shifts one time more than the operand width. The first bit it receives is the reset-time output of 0, and this bit is pushed out of the register again. A down-counter, loaded at reset, stops the result register after those N+1 shifts and raises the completion flag. A new addition is started by applying reset again with new operands.

Top module: `serial_moore_adder`

## Requirements
- R1: One clock edge with `rst` high clears `sum` to 0 and drives `done` low.
- R2: While `rst` is high, `op_a` and `op_b` are loaded in parallel. After release each operand register shifts toward bit 0 once per clock and fills its top bit with 0. Bit 0 is therefore presented first, and every clock beyond the width presents the pair 0,0.
- R3: The add machine has state {carry, sumbit}, with 00 = no carry and sum 0, 01 = no carry and sum 1, 10 = carry and sum 0, 11 = carry and sum 1. The next state has carry = majority(a, b, carry) and sumbit = a XOR b XOR carry, and reset puts it in state 00.
- R4: On the (N+1)-th rising edge after reset is released, `sum` equals (A + B) mod 2^N, using the operands loaded during reset, and `done` rises on that same edge.
- R5: `done` stays low for the first N edges after release, and once high it stays high until the next reset.
- R6: After reset is released, changes on `op_a` and `op_b` have no effect on the result. Once `done` is high, `sum` holds its value.
- R7: The carry out of bit N-1 is discarded, so all-ones plus one gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also loads the operands |
| op_a | input | WIDTH | First operand, captured while `rst` is high |
| op_b | input | WIDTH | Second operand, captured while `rst` is high |
| sum | output | WIDTH | Result register, valid once `done` is high |
| done | output | 1 | High once the addition has finished |

## Verification
After the single reset edge, the bench expects `sum` = 0 and `done` low at once. On each of the next N edges it expects `done` still low. On edge N+1 it expects the full sum and a raised `done`, and on three further edges it expects both to be unchanged. The bench drives inputs and samples outputs on falling edges, so each check falls exactly between the rising edges it counts. It scrambles the operand inputs right after reset is released, so that any late capture of them would show up as a wrong sum.

// File: rtl/serial_moore_adder_pkg.sv
package serial_moore_adder_pkg;

    typedef enum logic [1:0] {
        ST_C0_S0 = 2'b00,
        ST_C0_S1 = 2'b01,
        ST_C1_S0 = 2'b10,
        ST_C1_S1 = 2'b11
    } add_state_e;

    typedef struct packed {
        logic a;
        logic b;
    } bit_pair_t;

    function automatic logic state_carry(input add_state_e s);
        return s[1];
    endfunction

    function automatic logic state_sumbit(input add_state_e s);
        return s[0];
    endfunction

    function automatic add_state_e next_state(input add_state_e s, input bit_pair_t p);
        add_state_e n;
        if (!state_carry(s)) begin
            unique case ({p.a, p.b})
                2'b00:   n = ST_C0_S0;
                2'b01,
                2'b10:   n = ST_C0_S1;
                default: n = ST_C1_S0;
            endcase
        end else begin
            unique case ({p.a, p.b})
                2'b00:   n = ST_C0_S1;
                2'b01,
                2'b10:   n = ST_C1_S0;
                default: n = ST_C1_S1;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/sa_operand_shifter.sv
module sa_operand_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    output logic             lsb
);
    logic [WIDTH-1:0] q;

    always_ff @(posedge clk) begin
        if (load) begin
            q <= din;
        end else begin
            q <= {1'b0, q[WIDTH-1:1]};
        end
    end

    assign lsb = q[0];
endmodule

// File: rtl/sa_moore_fsm.sv
module sa_moore_fsm
    import serial_moore_adder_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bit_pair_t  pair,
    output add_state_e state,
    output logic       sum_bit
);
    add_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_C0_S0;
        end else begin
            state_q <= next_state(state_q, pair);
        end
    end

    assign state   = state_q;
    assign sum_bit = state_sumbit(state_q);
endmodule

// File: rtl/sa_stop_counter.sv
module sa_stop_counter #(
    parameter int START = 9,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] remaining,
    output logic             run
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(START);
        end else if (run) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign remaining = cnt_q;
    assign run       = (cnt_q != '0);
endmodule

// File: rtl/sa_result_shifter.sv
module sa_result_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (shift_en) begin
            q_r <= {bit_in, q_r[WIDTH-1:1]};
        end
    end

    assign q = q_r;
endmodule

// File: rtl/serial_moore_adder.sv
module serial_moore_adder
    import serial_moore_adder_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum,
    output logic             done
);
    // One extra shift flushes the reset-time output bit of the Moore machine.
    localparam int SHIFTS = WIDTH + 1;
    localparam int CNT_W  = $clog2(SHIFTS + 1);
    localparam int NOPS   = 2;

    logic [NOPS-1:0][WIDTH-1:0] ops_in;
    logic [NOPS-1:0]            ops_lsb;
    bit_pair_t                  pair;
    add_state_e                 cur_state;
    logic                       sum_bit;
    logic [CNT_W-1:0]           remaining;
    logic                       run;

    assign ops_in[0] = op_a;
    assign ops_in[1] = op_b;

    for (genvar i = 0; i < NOPS; i++) begin : g_operand
        sa_operand_shifter #(.WIDTH(WIDTH)) u_shift (
            .clk  (clk),
            .load (rst),
            .din  (ops_in[i]),
            .lsb  (ops_lsb[i])
        );
    end

    assign pair.a = ops_lsb[0];
    assign pair.b = ops_lsb[1];

    sa_moore_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .pair    (pair),
        .state   (cur_state),
        .sum_bit (sum_bit)
    );

    sa_stop_counter #(.START(SHIFTS), .CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .remaining (remaining),
        .run       (run)
    );

    sa_result_shifter #(.WIDTH(WIDTH)) u_res (
        .clk      (clk),
        .rst      (rst),
        .shift_en (run),
        .bit_in   (sum_bit),
        .q        (sum)
    );

    assign done = ~run;
endmodule

// File: rtl/serial_moore_adder_chk.sv
module serial_moore_adder_chk
    import serial_moore_adder_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] sum,
    input logic             done,
    input logic [CNT_W-1:0] remaining,
    input add_state_e       cur_state,
    input bit_pair_t        pair
);
    function automatic logic maj3(input logic x, input logic y, input logic z);
        return (x & y) | (x & z) | (y & z);
    endfunction

    // R5: completion is sticky until reset
    p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R6: result frozen after completion
    p_sum_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(sum));

    // R4: the counter steps down by one per cycle while the addition runs
    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        !done |=> (remaining == $past(remaining) - 1'b1));

    // R3: carry follows the majority of the operand bits and the old carry
    p_carry_rule_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cur_state[1] == maj3($past(pair.a), $past(pair.b), $past(cur_state[1]))));

    // R3: sum bit is the parity of the operand bits and the old carry
    p_sumbit_rule_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cur_state[0] == ($past(pair.a) ^ $past(pair.b) ^ $past(cur_state[1]))));

    // R2: the result register takes the machine's sum bit into its top position
    p_sum_shift_r2: assert property (@(posedge clk) disable iff (rst)
        !done |=> (sum[WIDTH-1] == $past(cur_state[0])));
endmodule

bind serial_moore_adder serial_moore_adder_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sum       (sum),
    .done      (done),
    .remaining (remaining),
    .cur_state (cur_state),
    .pair      (pair)
);

// File: tb/serial_moore_adder_tb.sv
module serial_moore_adder_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] sum;
    logic         done;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    serial_moore_adder #(.WIDTH(W)) u_dut (
        .clk  (clk),
        .rst  (rst),
        .op_a (op_a),
        .op_b (op_b),
        .sum  (sum),
        .done (done)
    );

    function automatic logic [W-1:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] full;
        full = {1'b0, a} + {1'b0, b};
        return full[W-1:0];
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] exp;
        exp = ref_sum(a, b);
        @(negedge clk);
        op_a = a;
        op_b = b;
        rst  = 1'b1;
        @(negedge clk);
        check("R1 sum after reset", sum, '0);
        check("R1 done after reset", W'(done), W'(0));
        rst  = 1'b0;
        op_a = W'($urandom);   // R6: late input changes must not matter
        op_b = ~a;
        for (int i = 0; i < W; i++) @(negedge clk);
        check("R5 done low after N edges", W'(done), W'(0));
        @(negedge clk);
        check("R4 done at edge N+1", W'(done), W'(1));
        check("R4 R2 R3 sum at edge N+1", sum, exp);
        op_a = W'($urandom);
        op_b = W'($urandom);
        for (int i = 0; i < 3; i++) @(negedge clk);
        check("R6 sum held", sum, exp);
        check("R5 done held", W'(done), W'(1));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        run_add(8'hFF, 8'h01);   // R7 all ones plus one
        check("R7 wraps to zero", sum, 8'h00);
        run_add(8'h00, 8'h00);
        run_add(8'hFF, 8'hFF);   // R7 carry through every bit
        run_add(8'h80, 8'h80);   // R7 only the top carry
        run_add(8'hAA, 8'h55);
        run_add(8'h55, 8'h55);
        run_add(8'h01, 8'h00);   // R2 lowest bit first
        run_add(8'h00, 8'h80);
        for (int n = 0; n < 40; n++) begin
            run_add(W'($urandom), W'($urandom));
        end
        if (!ended) begin
            ended = 1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule